// File: doc/BRIEF.md
# Critical-Word-First Cache Line Refill Controller

This block handles a cache miss by fetching the whole multi-word line from memory and writing it into the data array. It takes the missed word address from an outside tag lookup. It then issues one burst request to memory and writes each returning beat into the line. The word the processor asked for is handed back as soon as its beat shows up, so the processor resumes before the line is complete.

A mode input picks the burst order for each miss. In critical-word-first order the burst begins at the missed word and wraps around the line. In early-restart order the burst begins at word 0, and the missed word is still forwarded on the cycle it arrives. The line is declared valid one cycle after its last word is written. After the early forward, the cache stays blocking: any further processor access is held until the refill has finished. A beat counter closes the burst after exactly one line of beats and flags any beat whose last flag disagrees with that count.

Top module: `cwf_refill_ctrl`

## Requirements
- R1: After reset the block is idle: `miss_ready` is 1, and `mem_req_valid`, `fill_we`, `cpu_fwd_valid`, `line_valid_set`, `beat_err` and `cpu_hold` are 0.
- R2: When a miss is accepted in critical-word-first mode (`mode_cwf`=1), `mem_req_valid` is high for exactly the next cycle. In that cycle `mem_req_line` is the line address (`miss_addr` above the word-offset bits) and `mem_req_start` is the missed word offset (the low log2(WORDS) bits of `miss_addr`).
- R3: When a miss is accepted in early-restart mode (`mode_cwf`=0), the request has the same timing and line, and `mem_req_start` is 0.
- R4: The k-th accepted beat (k counted from 0) is written in the cycle it arrives. `fill_we` is 1, `fill_word` = (start + k) mod WORDS, `fill_line` is the missed line, and `fill_data` is the beat data. `fill_we` is 0 in cycles with no beat.
- R5: `cpu_fwd_valid` is 1 in exactly one cycle per miss: the cycle in which the beat for the missed word arrives. In that cycle `cpu_fwd_data` equals that beat's data.
- R6: `cpu_hold` is 1 from the cycle the miss is presented until the forward cycle, and 0 in the forward cycle itself. After the forward and until the refill has finished, `cpu_hold` follows `acc_valid`. In the idle state with no miss presented it is 0.
- R7: `line_valid_set` pulses for one cycle in the cycle after the WORDS-th beat, with `line_valid_idx` equal to the missed line. `miss_ready` returns to 1 in the cycle after that.
- R8: `beat_err` is 1 on a beat whose `mem_beat_last` is set on any beat other than the WORDS-th, or is clear on the WORDS-th beat. The refill still ends after WORDS beats.
- R9: A `miss_valid` presented while `miss_ready` is 0 is ignored: it starts no new request and leaves the line being filled unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_cwf | input | 1 | 1: critical-word-first order, 0: early-restart order; sampled when a miss is accepted |
| miss_valid | input | 1 | A processor access missed |
| miss_addr | input | ADDR_W | Word address of the missed access |
| miss_ready | output | 1 | Controller idle, able to accept a miss |
| acc_valid | input | 1 | Processor presents a further access while the refill is in progress |
| cpu_hold | output | 1 | Stall to the processor |
| cpu_fwd_valid | output | 1 | Missed word returned to the processor |
| cpu_fwd_data | output | DATA_W | Returned word |
| mem_req_valid | output | 1 | Burst request pulse |
| mem_req_line | output | ADDR_W-log2(WORDS) | Line address of the burst |
| mem_req_start | output | log2(WORDS) | First word of the wrapping burst |
| mem_beat_valid | input | 1 | Memory beat present |
| mem_beat_data | input | DATA_W | Beat data |
| mem_beat_last | input | 1 | Memory marks its final beat |
| fill_we | output | 1 | Data array word write |
| fill_line | output | ADDR_W-log2(WORDS) | Line being written |
| fill_word | output | log2(WORDS) | Word within the line |
| fill_data | output | DATA_W | Word written |
| line_valid_set | output | 1 | Mark the filled line valid |
| line_valid_idx | output | ADDR_W-log2(WORDS) | Line to mark valid |
| beat_err | output | 1 | Last flag disagrees with the beat count |

## Verification
The bench targets misses whose word is the last in the line. A design that does not wrap the word index there writes past the line or stalls at the top word. It checks misses at word 0 in both modes, where the forward lands on the very first beat, and early-restart misses on the last word, where the forward comes only at the end of the burst. A design that mixes up the modes would forward at the wrong beat and release `cpu_hold` too early or too late. It sends last flags that are early or missing, which a controller ending on the flag instead of the count would treat as a short or runaway burst. It also raises new misses during a fill, which a controller that does not block would take as a second request or a changed line.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_FILL = 2'd2,
      ST_DONE = 2'd3
   } cwf_state_e;

endpackage

// File: rtl/cwf_word_order.sv
// Maps a beat ordinal to its word slot in a wrapping burst.
module cwf_word_order #(
   parameter int WORDS = 4,
   localparam int OFF_W = $clog2(WORDS)
) (
   input  logic [OFF_W-1:0] start,
   input  logic [OFF_W-1:0] ordinal,
   output logic [OFF_W-1:0] slot
);
   // WORDS is a power of two, so dropping the carry is the modulo.
   logic [OFF_W:0] sum;
   assign sum  = {1'b0, start} + {1'b0, ordinal};
   assign slot = sum[OFF_W-1:0];
endmodule

// File: rtl/cwf_beat_counter.sv
// Counts beats of one line and checks the memory's last flag against the count.
module cwf_beat_counter #(
   parameter int WORDS      = 4,
   parameter bit CHECK_LAST = 1'b1,
   localparam int OFF_W = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             beat,
   input  logic             last,
   output logic [OFF_W-1:0] count,
   output logic             final_beat,
   output logic             err
);
   localparam logic [OFF_W-1:0] TOP = OFF_W'(WORDS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) count <= '0;
      else if (beat)       count <= count + 1'b1;
   end

   assign final_beat = beat && (count == TOP);

   generate
      if (CHECK_LAST) begin : g_chk
         assign err = beat && (last != (count == TOP));
      end else begin : g_nochk
         assign err = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/cwf_refill_ctrl.sv
module cwf_refill_ctrl
   import cwf_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 32,
   parameter int WORDS      = 4,
   parameter bit CHECK_LAST = 1'b1,
   localparam int OFF_W  = $clog2(WORDS),
   localparam int LINE_W = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_cwf,
   input  logic              miss_valid,
   input  logic [ADDR_W-1:0] miss_addr,
   output logic              miss_ready,
   input  logic              acc_valid,
   output logic              cpu_hold,
   output logic              cpu_fwd_valid,
   output logic [DATA_W-1:0] cpu_fwd_data,
   output logic              mem_req_valid,
   output logic [LINE_W-1:0] mem_req_line,
   output logic [OFF_W-1:0]  mem_req_start,
   input  logic              mem_beat_valid,
   input  logic [DATA_W-1:0] mem_beat_data,
   input  logic              mem_beat_last,
   output logic              fill_we,
   output logic [LINE_W-1:0] fill_line,
   output logic [OFF_W-1:0]  fill_word,
   output logic [DATA_W-1:0] fill_data,
   output logic              line_valid_set,
   output logic [LINE_W-1:0] line_valid_idx,
   output logic              beat_err
);

   generate
      if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
         $error("WORDS must be a power of two, at least 2");
      end
      if (ADDR_W <= OFF_W) begin : g_bad_addr
         $error("ADDR_W must exceed the word offset width");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
   endgenerate

   cwf_state_e        state;
   logic [LINE_W-1:0] line_q;
   logic [OFF_W-1:0]  crit_q;
   logic [OFF_W-1:0]  start_q;
   logic              fwd_done_q;

   logic              beat_in;
   logic              final_beat;
   logic              fwd_now;
   logic [OFF_W-1:0]  ordinal;
   logic [OFF_W-1:0]  slot;

   assign beat_in = (state == ST_FILL) && mem_beat_valid;

   cwf_beat_counter #(
      .WORDS      (WORDS),
      .CHECK_LAST (CHECK_LAST)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (state == ST_REQ),
      .beat       (beat_in),
      .last       (mem_beat_last),
      .count      (ordinal),
      .final_beat (final_beat),
      .err        (beat_err)
   );

   cwf_word_order #(
      .WORDS   (WORDS)
   ) u_order (
      .start   (start_q),
      .ordinal (ordinal),
      .slot    (slot)
   );

   assign fwd_now = beat_in && (slot == crit_q) && !fwd_done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         line_q     <= '0;
         crit_q     <= '0;
         start_q    <= '0;
         fwd_done_q <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (miss_valid) begin
                  line_q     <= miss_addr[ADDR_W-1:OFF_W];
                  crit_q     <= miss_addr[OFF_W-1:0];
                  start_q    <= mode_cwf ? miss_addr[OFF_W-1:0] : '0;
                  fwd_done_q <= 1'b0;
                  state      <= ST_REQ;
               end
            end
            ST_REQ:  state <= ST_FILL;
            ST_FILL: begin
               if (fwd_now)    fwd_done_q <= 1'b1;
               if (final_beat) state      <= ST_DONE;
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign miss_ready     = (state == ST_IDLE);
   assign mem_req_valid  = (state == ST_REQ);
   assign mem_req_line   = line_q;
   assign mem_req_start  = start_q;

   assign fill_we        = beat_in;
   assign fill_line      = line_q;
   assign fill_word      = slot;
   assign fill_data      = mem_beat_data;

   assign cpu_fwd_valid  = fwd_now;
   assign cpu_fwd_data   = mem_beat_data;

   assign line_valid_set = (state == ST_DONE);
   assign line_valid_idx = line_q;

   always_comb begin
      unique case (state)
         ST_IDLE: cpu_hold = miss_valid;
         ST_REQ:  cpu_hold = 1'b1;
         ST_FILL: cpu_hold = fwd_now ? 1'b0 : (fwd_done_q ? acc_valid : 1'b1);
         ST_DONE: cpu_hold = acc_valid;
         default: cpu_hold = 1'b1;
      endcase
   end

endmodule

// File: rtl/cwf_refill_chk.sv
module cwf_refill_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int WORDS  = 4,
   localparam int OFF_W  = $clog2(WORDS),
   localparam int LINE_W = ADDR_W - OFF_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_cwf,
   input logic              miss_valid,
   input logic [ADDR_W-1:0] miss_addr,
   input logic              miss_ready,
   input logic              cpu_hold,
   input logic              cpu_fwd_valid,
   input logic              mem_req_valid,
   input logic [LINE_W-1:0] mem_req_line,
   input logic [OFF_W-1:0]  mem_req_start,
   input logic              fill_we,
   input logic [LINE_W-1:0] fill_line,
   input logic [OFF_W-1:0]  fill_word,
   input logic              line_valid_set,
   input logic [LINE_W-1:0] line_valid_idx
);
   logic [OFF_W-1:0]  cap_word;
   logic [LINE_W-1:0] cap_line;
   logic              cap_mode;
   logic [OFF_W-1:0]  prev_word;
   logic [OFF_W:0]    wr_cnt;
   logic [1:0]        fwd_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_word  <= '0;
         cap_line  <= '0;
         cap_mode  <= 1'b0;
         prev_word <= '0;
         wr_cnt    <= '0;
         fwd_cnt   <= '0;
      end else begin
         if (miss_valid && miss_ready) begin
            cap_word <= miss_addr[OFF_W-1:0];
            cap_line <= miss_addr[ADDR_W-1:OFF_W];
            cap_mode <= mode_cwf;
         end
         if (mem_req_valid) begin
            wr_cnt  <= '0;
            fwd_cnt <= '0;
         end else begin
            if (fill_we) begin
               wr_cnt    <= wr_cnt + 1'b1;
               prev_word <= fill_word;
            end
            if (cpu_fwd_valid && fwd_cnt != 2'd3) fwd_cnt <= fwd_cnt + 1'b1;
         end
      end
   end

   a_r2_cwf_start: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && cap_mode |-> mem_req_start == cap_word && mem_req_line == cap_line);

   a_r3_er_start: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !cap_mode |-> mem_req_start == '0 && mem_req_line == cap_line);

   a_r4_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
      fill_we && wr_cnt != '0 |-> fill_word == OFF_W'(prev_word + 1'b1) && fill_line == cap_line);

   a_r5_single_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_fwd_valid |-> fill_we && fill_word == cap_word && fwd_cnt == 2'd0);

   a_r6_hold_before_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      fill_we && fwd_cnt == 2'd0 && !cpu_fwd_valid |-> cpu_hold);

   a_r7_valid_after_line: assert property (@(posedge clk) disable iff (!rst_n)
      line_valid_set |-> wr_cnt == (OFF_W+1)'(WORDS) && fwd_cnt == 2'd1 && line_valid_idx == cap_line);

   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_req_valid, fill_we, line_valid_set}));

   a_r9_single_req: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |=> !mem_req_valid && !miss_ready);

endmodule

bind cwf_refill_ctrl cwf_refill_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .WORDS  (WORDS)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .mode_cwf       (mode_cwf),
   .miss_valid     (miss_valid),
   .miss_addr      (miss_addr),
   .miss_ready     (miss_ready),
   .cpu_hold       (cpu_hold),
   .cpu_fwd_valid  (cpu_fwd_valid),
   .mem_req_valid  (mem_req_valid),
   .mem_req_line   (mem_req_line),
   .mem_req_start  (mem_req_start),
   .fill_we        (fill_we),
   .fill_line      (fill_line),
   .fill_word      (fill_word),
   .line_valid_set (line_valid_set),
   .line_valid_idx (line_valid_idx)
);

// File: tb/cwf_refill_ctrl_tb.sv
module cwf_refill_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 16;
   localparam int DATA_W = 32;
   localparam int WORDS  = 4;
   localparam int OFF_W  = $clog2(WORDS);
   localparam int LINE_W = ADDR_W - OFF_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              mode_cwf = 1'b0;
   logic              miss_valid = 1'b0;
   logic [ADDR_W-1:0] miss_addr = '0;
   logic              miss_ready;
   logic              acc_valid = 1'b0;
   logic              cpu_hold;
   logic              cpu_fwd_valid;
   logic [DATA_W-1:0] cpu_fwd_data;
   logic              mem_req_valid;
   logic [LINE_W-1:0] mem_req_line;
   logic [OFF_W-1:0]  mem_req_start;
   logic              mem_beat_valid = 1'b0;
   logic [DATA_W-1:0] mem_beat_data = '0;
   logic              mem_beat_last = 1'b0;
   logic              fill_we;
   logic [LINE_W-1:0] fill_line;
   logic [OFF_W-1:0]  fill_word;
   logic [DATA_W-1:0] fill_data;
   logic              line_valid_set;
   logic [LINE_W-1:0] line_valid_idx;
   logic              beat_err;

   int n_checks = 0;
   int n_fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cwf_refill_ctrl #(
      .ADDR_W (ADDR_W), .DATA_W (DATA_W), .WORDS (WORDS)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .mode_cwf (mode_cwf),
      .miss_valid (miss_valid), .miss_addr (miss_addr), .miss_ready (miss_ready),
      .acc_valid (acc_valid), .cpu_hold (cpu_hold),
      .cpu_fwd_valid (cpu_fwd_valid), .cpu_fwd_data (cpu_fwd_data),
      .mem_req_valid (mem_req_valid), .mem_req_line (mem_req_line),
      .mem_req_start (mem_req_start), .mem_beat_valid (mem_beat_valid),
      .mem_beat_data (mem_beat_data), .mem_beat_last (mem_beat_last),
      .fill_we (fill_we), .fill_line (fill_line), .fill_word (fill_word),
      .fill_data (fill_data), .line_valid_set (line_valid_set),
      .line_valid_idx (line_valid_idx), .beat_err (beat_err)
   );

   function automatic int exp_start(input logic [ADDR_W-1:0] a, input logic cwf);
      return cwf ? int'(a[OFF_W-1:0]) : 0;
   endfunction

   function automatic int exp_slot(input int start, input int k);
      return (start + k) % WORDS;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
   endtask

   // bad_pos: beat ordinal whose last flag is inverted, -1 for none.
   task automatic do_miss(input logic [ADDR_W-1:0] addr, input logic cwf,
                          input int bad_pos, input bit intrude, input int max_gap);
      int  start;
      int  crit;
      bit  fwd_seen;
      logic [LINE_W-1:0] line;
      start = exp_start(addr, cwf);
      crit  = int'(addr[OFF_W-1:0]);
      line  = addr[ADDR_W-1:OFF_W];
      fwd_seen = 1'b0;

      @(negedge clk);
      miss_valid = 1'b1; miss_addr = addr; mode_cwf = cwf; acc_valid = 1'b0;
      #1;
      chk("R6 hold on miss", 64'(cpu_hold), 64'd1);
      chk("R9 ready idle", 64'(miss_ready), 64'd1);

      @(negedge clk);
      miss_valid = intrude;
      miss_addr  = ~addr;
      mode_cwf   = ~cwf;
      #1;
      chk("R2/R3 req valid", 64'(mem_req_valid), 64'd1);
      chk(cwf ? "R2 start" : "R3 start", 64'(mem_req_start), 64'(start));
      chk("R2 line", 64'(mem_req_line), 64'(line));
      chk("R6 hold in req", 64'(cpu_hold), 64'd1);
      chk("R9 busy", 64'(miss_ready), 64'd0);

      for (int k = 0; k < WORDS; k++) begin
         int gaps;
         bit lst;
         logic [DATA_W-1:0] d;
         gaps = int'($urandom_range(max_gap, 0));
         for (int g = 0; g < gaps; g++) begin
            @(negedge clk);
            mem_beat_valid = 1'b0; acc_valid = 1'($urandom);
            #1;
            chk("R4 no write in gap", 64'(fill_we), 64'd0);
            chk("R6 hold in gap", 64'(cpu_hold), fwd_seen ? 64'(acc_valid) : 64'd1);
            chk("R9 no new req", 64'(mem_req_valid), 64'd0);
         end
         @(negedge clk);
         d   = $urandom;
         lst = (k == WORDS-1) ^ (k == bad_pos);
         mem_beat_valid = 1'b1; mem_beat_data = d; mem_beat_last = lst;
         acc_valid = 1'($urandom);
         #1;
         chk("R4 we", 64'(fill_we), 64'd1);
         chk("R4 word", 64'(fill_word), 64'(exp_slot(start, k)));
         chk("R4 line", 64'(fill_line), 64'(line));
         chk("R4 data", 64'(fill_data), 64'(d));
         chk("R5 fwd", 64'(cpu_fwd_valid), 64'(exp_slot(start, k) == crit));
         if (exp_slot(start, k) == crit) begin
            chk("R5 fwd data", 64'(cpu_fwd_data), 64'(d));
            chk("R6 release", 64'(cpu_hold), 64'd0);
            fwd_seen = 1'b1;
         end else begin
            chk("R6 hold on beat", 64'(cpu_hold), fwd_seen ? 64'(acc_valid) : 64'd1);
         end
         chk("R8 beat_err", 64'(beat_err), 64'(lst != (k == WORDS-1)));
         chk("R7 no early valid", 64'(line_valid_set), 64'd0);
      end

      @(negedge clk);
      mem_beat_valid = 1'b0; mem_beat_last = 1'b0; acc_valid = 1'($urandom);
      #1;
      chk("R7 valid set", 64'(line_valid_set), 64'd1);
      chk("R7 valid idx", 64'(line_valid_idx), 64'(line));
      chk("R6 hold done", 64'(cpu_hold), 64'(acc_valid));
      chk("R7 not ready yet", 64'(miss_ready), 64'd0);

      @(negedge clk);
      miss_valid = 1'b0; acc_valid = 1'b0;
      #1;
      chk("R7 ready again", 64'(miss_ready), 64'd1);
      chk("R7 pulse ends", 64'(line_valid_set), 64'd0);
      chk("R6 idle hold", 64'(cpu_hold), 64'd0);
      chk("R9 no req after", 64'(mem_req_valid), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      int seed;
      seed = int'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      #1;
      chk("R1 ready", 64'(miss_ready), 64'd1);
      chk("R1 req", 64'(mem_req_valid), 64'd0);
      chk("R1 we", 64'(fill_we), 64'd0);
      chk("R1 valid", 64'(line_valid_set), 64'd0);
      chk("R1 fwd", 64'(cpu_fwd_valid), 64'd0);
      chk("R1 hold", 64'(cpu_hold), 64'd0);
      chk("R1 err", 64'(beat_err), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 ready after release", 64'(miss_ready), 64'd1);

      do_miss(16'h1233, 1'b1, -1, 1'b0, 0);   // wrap from top word
      do_miss(16'h0040, 1'b1, -1, 1'b0, 1);   // forward on first beat
      do_miss(16'h7FF3, 1'b0, -1, 1'b0, 0);   // early restart, forward last
      do_miss(16'h0100, 1'b0, -1, 1'b0, 2);   // early restart, word 0
      do_miss(16'h2222, 1'b1,  1, 1'b0, 0);   // early last flag
      do_miss(16'h3331, 1'b1, WORDS-1, 1'b0, 0); // missing last flag
      do_miss(16'h4561, 1'b1, -1, 1'b1, 1);   // misses raised during fill
      do_miss(16'h4562, 1'b0, -1, 1'b1, 0);

      for (int i = 0; i < 30; i++) begin
         do_miss(ADDR_W'($urandom), 1'($urandom), -1, 1'($urandom), 2);
      end

      summary();
      $finish;
   end
endmodule